// File: doc/BRIEF.md
# Bulk IN Endpoint Controller

This block is the device-side control for a single bulk or interrupt IN endpoint. Firmware loads a packet byte by byte into a 64-entry packet buffer, then arms the endpoint by setting a ready flag. When the bus side delivers an IN token, the block answers either with a NAK handshake (nothing armed) or with a tagged byte stream: a start marker carrying the data PID, the payload bytes in write order, and an end marker. Serial encoding, CRC and the OUT direction are left to other blocks.

After a data packet the block waits for the host verdict. A host ACK retires the packet: the buffer empties, the ready flag drops, the data toggle flips and a complete flag is set, which raises the interrupt when enabled. A timeout strobe leaves the packet armed; the buffer read position rewinds, so the next IN token resends identical bytes under the same PID without firmware help. Firmware can cancel at any time by clearing the ready flag, which also empties the buffer.

Top module: `bulk_in_ep`

## Requirements
- R1: While `cfg_en` is low, IN tokens get no response of any kind and `st_toggle` is held at 0 (DATA0).
- R2: An IN token seen while `st_rdy` is 0 and `cfg_en` is 1 produces `resp_nak` high for exactly the one cycle after the token.
- R3: An IN token seen while `st_rdy` is 1 produces `pkt_start` in the next cycle with `tx_pid` equal to the toggle (0 = DATA0, 1 = DATA1), then one `byte_vld` cycle per stored byte in write order on `tx_data`, then one `pkt_end` cycle; at most one of `resp_nak`, `pkt_start`, `byte_vld`, `pkt_end` is high in any cycle.
- R4: Arming with an empty buffer sends a zero-length packet: `pkt_start` is followed directly by `pkt_end` with no `byte_vld`.
- R5: A `fw_clr_rdy` pulse clears `st_rdy` and empties the buffer (`st_count` = 0) in the next cycle, abandons any packet being streamed or awaiting a verdict, and later tokens get NAK.
- R6: `bus_ack` while a sent packet awaits its verdict sets `st_cmpl`, clears `st_rdy`, empties the buffer and flips `st_toggle`; further tokens get NAK until the endpoint is armed again.
- R7: `irq` is high exactly while `st_cmpl` and `st_ie` are both 1; `fw_clr_cmpl` clears `st_cmpl`.
- R8: `bus_tmo` while a packet awaits its verdict keeps the endpoint armed; the next IN token resends the same bytes with the same `tx_pid`.
- R9: A write when the buffer holds 64 bytes is dropped, `st_count` stays at 64 and `wr_err` pulses in the next cycle.
- R10: A write while `st_rdy` or `st_cmpl` is 1 is dropped and `wr_err` pulses in the next cycle.
- R11: When `bus_ack` and `fw_clr_rdy` arrive in the same cycle for a packet awaiting its verdict, the ACK wins: `st_cmpl` is set and the toggle flips.
- R12: `bus_ack` or `bus_tmo` arriving when no packet awaits a verdict has no effect on `st_cmpl`, `st_rdy`, `st_count` or the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Endpoint enabled and configured |
| fw_wr | input | 1 | Firmware byte write strobe |
| fw_wdata | input | 8 | Firmware write byte |
| fw_set_rdy | input | 1 | Arm the endpoint |
| fw_clr_rdy | input | 1 | Cancel and flush the packet |
| fw_clr_cmpl | input | 1 | Clear the complete flag |
| fw_ie_wr | input | 1 | Write the interrupt enable |
| fw_ie_val | input | 1 | Interrupt enable value |
| bus_in_tok | input | 1 | IN token for this endpoint |
| bus_ack | input | 1 | Host acknowledged the packet |
| bus_tmo | input | 1 | Host acknowledgement timeout strobe |
| resp_nak | output | 1 | Send NAK handshake |
| pkt_start | output | 1 | Data packet start marker |
| tx_pid | output | 1 | Data PID with start (0 DATA0, 1 DATA1) |
| byte_vld | output | 1 | Payload byte valid |
| tx_data | output | 8 | Payload byte |
| pkt_end | output | 1 | Data packet end marker |
| st_rdy | output | 1 | Ready flag |
| st_cmpl | output | 1 | Complete flag |
| st_ie | output | 1 | Interrupt enable |
| st_toggle | output | 1 | Current data toggle |
| st_count | output | 7 | Bytes in buffer |
| wr_err | output | 1 | Rejected write strobe |
| irq | output | 1 | Endpoint interrupt |

## Verification
The function pair that can share a cycle is the host ACK retiring a packet and firmware clearing the ready flag to cancel it. The bench drives both strobes on the same clock edge while a packet is waiting for its verdict and judges the outcome at the ports: the complete flag must be set, the toggle must flip and the buffer must be empty, which proves the ACK took priority over the cancel. A second overlap, a timeout followed by a cancel, is checked by a NAK on the next token with the toggle left unchanged.

// File: rtl/bulk_in_ep_pkg.sv
package bulk_in_ep_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_NAK,
        SQ_HDR,
        SQ_BODY,
        SQ_TAIL,
        SQ_WAIT
    } seq_state_e;

    typedef struct packed {
        logic rdy;
        logic cmpl;
        logic ie;
        logic tgl;
    } ep_stat_t;

    typedef struct packed {
        logic nak;
        logic start;
        logic vld;
        logic fin;
    } tx_ctl_t;

    function automatic logic sq_busy(seq_state_e s);
        return (s == SQ_HDR) || (s == SQ_BODY) || (s == SQ_TAIL) || (s == SQ_WAIT);
    endfunction

endpackage

// File: rtl/ep_pkt_fifo.sv
module ep_pkt_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          flush,
    input  logic          rd_adv,
    input  logic          rewind,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          rd_last
);
    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            mem[count[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            count  <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) begin
                count <= count + CW'(1);
            end
            if (rewind) begin
                rd_ptr <= '0;
            end else if (rd_adv) begin
                rd_ptr <= rd_ptr + CW'(1);
            end
        end
    end

    assign rd_data = mem[rd_ptr[AW-1:0]];
    assign full    = (count == CW'(DEPTH));
    assign rd_last = (rd_ptr == count - CW'(1));
endmodule

// File: rtl/ep_status_reg.sv
module ep_status_reg
    import bulk_in_ep_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_en,
    input  logic     set_rdy,
    input  logic     clr_rdy,
    input  logic     clr_cmpl,
    input  logic     ie_wr,
    input  logic     ie_val,
    input  logic     ack_done,
    output ep_stat_t stat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            if (ack_done || clr_rdy) begin
                stat.rdy <= 1'b0;
            end else if (set_rdy) begin
                stat.rdy <= 1'b1;
            end

            if (ack_done) begin
                stat.cmpl <= 1'b1;
            end else if (clr_cmpl) begin
                stat.cmpl <= 1'b0;
            end

            if (ie_wr) begin
                stat.ie <= ie_val;
            end

            if (!cfg_en) begin
                stat.tgl <= 1'b0;
            end else if (ack_done) begin
                stat.tgl <= ~stat.tgl;
            end
        end
    end
endmodule

// File: rtl/ep_tx_seq.sv
module ep_tx_seq
    import bulk_in_ep_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_en,
    input  logic          tok,
    input  logic          ack,
    input  logic          tmo,
    input  logic          rdy,
    input  logic          abort,
    input  logic [CW-1:0] count,
    input  logic          rd_last,
    output logic          rd_adv,
    output logic          rewind,
    output logic          ack_done,
    output tx_ctl_t       ctl
);
    seq_state_e state, nxt;

    always_comb begin
        nxt      = state;
        rd_adv   = 1'b0;
        rewind   = 1'b0;
        ack_done = 1'b0;
        case (state)
            SQ_IDLE: if (tok && cfg_en) nxt = rdy ? SQ_HDR : SQ_NAK;
            SQ_NAK:  nxt = SQ_IDLE;
            SQ_HDR:  nxt = (count == '0) ? SQ_TAIL : SQ_BODY;
            SQ_BODY: begin
                rd_adv = 1'b1;
                if (rd_last) nxt = SQ_TAIL;
            end
            SQ_TAIL: nxt = SQ_WAIT;
            SQ_WAIT: begin
                if (ack) begin
                    ack_done = 1'b1;
                    nxt      = SQ_IDLE;
                end else if (tmo) begin
                    rewind = 1'b1;
                    nxt    = SQ_IDLE;
                end
            end
            default: nxt = SQ_IDLE;
        endcase
        if (!ack_done && (!cfg_en || abort)) begin
            if (sq_busy(state)) begin
                rewind = 1'b1;
            end
            rd_adv = 1'b0;
            nxt    = SQ_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        ctl.nak   = (state == SQ_NAK);
        ctl.start = (state == SQ_HDR);
        ctl.vld   = (state == SQ_BODY);
        ctl.fin   = (state == SQ_TAIL);
    end
endmodule

// File: rtl/bulk_in_ep.sv
module bulk_in_ep
    import bulk_in_ep_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_en,
    input  logic          fw_wr,
    input  logic [DW-1:0] fw_wdata,
    input  logic          fw_set_rdy,
    input  logic          fw_clr_rdy,
    input  logic          fw_clr_cmpl,
    input  logic          fw_ie_wr,
    input  logic          fw_ie_val,
    input  logic          bus_in_tok,
    input  logic          bus_ack,
    input  logic          bus_tmo,
    output logic          resp_nak,
    output logic          pkt_start,
    output logic          tx_pid,
    output logic          byte_vld,
    output logic [DW-1:0] tx_data,
    output logic          pkt_end,
    output logic          st_rdy,
    output logic          st_cmpl,
    output logic          st_ie,
    output logic          st_toggle,
    output logic [CW-1:0] st_count,
    output logic          wr_err,
    output logic          irq
);
    ep_stat_t      stat;
    tx_ctl_t       ctl;
    logic          ack_done, rd_adv, rewind, full, rd_last, wr_ok, wr_bad;
    logic [CW-1:0] count;

    assign wr_bad = fw_wr && (full || stat.rdy || stat.cmpl);
    assign wr_ok  = fw_wr && !wr_bad;

    ep_pkt_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ok),
        .wr_data (fw_wdata),
        .flush   (fw_clr_rdy || ack_done),
        .rd_adv  (rd_adv),
        .rewind  (rewind),
        .rd_data (tx_data),
        .count   (count),
        .full    (full),
        .rd_last (rd_last)
    );

    ep_status_reg u_stat (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .set_rdy  (fw_set_rdy),
        .clr_rdy  (fw_clr_rdy),
        .clr_cmpl (fw_clr_cmpl),
        .ie_wr    (fw_ie_wr),
        .ie_val   (fw_ie_val),
        .ack_done (ack_done),
        .stat     (stat)
    );

    ep_tx_seq #(.DEPTH(DEPTH)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .tok      (bus_in_tok),
        .ack      (bus_ack),
        .tmo      (bus_tmo),
        .rdy      (stat.rdy),
        .abort    (fw_clr_rdy),
        .count    (count),
        .rd_last  (rd_last),
        .rd_adv   (rd_adv),
        .rewind   (rewind),
        .ack_done (ack_done),
        .ctl      (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_err <= 1'b0;
        end else begin
            wr_err <= wr_bad;
        end
    end

    assign resp_nak  = ctl.nak;
    assign pkt_start = ctl.start;
    assign tx_pid    = stat.tgl;
    assign byte_vld  = ctl.vld;
    assign pkt_end   = ctl.fin;
    assign st_rdy    = stat.rdy;
    assign st_cmpl   = stat.cmpl;
    assign st_ie     = stat.ie;
    assign st_toggle = stat.tgl;
    assign st_count  = count;
    assign irq       = stat.cmpl && stat.ie;
endmodule

// File: rtl/bulk_in_ep_chk.sv
module bulk_in_ep_chk #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_en,
    input logic          bus_in_tok,
    input logic          bus_ack,
    input logic          fw_wr,
    input logic          fw_clr_rdy,
    input logic          fw_clr_cmpl,
    input logic          resp_nak,
    input logic          pkt_start,
    input logic          byte_vld,
    input logic          pkt_end,
    input logic          st_rdy,
    input logic          st_cmpl,
    input logic          st_toggle,
    input logic [CW-1:0] st_count,
    input logic          wr_err
);
    assert_no_reply_disabled_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_en) |-> !(resp_nak || pkt_start));

    assert_nak_after_token_R2: assert property (@(posedge clk) disable iff (rst)
        resp_nak |-> $past(bus_in_tok && cfg_en && !st_rdy));

    assert_start_after_token_R3: assert property (@(posedge clk) disable iff (rst)
        pkt_start |-> $past(bus_in_tok && cfg_en && st_rdy));

    assert_one_marker_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({resp_nak, pkt_start, byte_vld, pkt_end}));

    assert_cancel_flushes_R5: assert property (@(posedge clk) disable iff (rst)
        $past(fw_clr_rdy) |-> (st_count == '0 && !st_rdy));

    assert_cmpl_retires_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(st_cmpl) |-> (!st_rdy && st_count == '0 && $past(bus_ack)));

    assert_toggle_on_ack_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_en) && !$stable(st_toggle)) |-> $past(bus_ack));

    assert_cmpl_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(st_cmpl) |-> $past(fw_clr_cmpl));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        st_count <= CW'(DEPTH));

    assert_err_from_write_R10: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(fw_wr));
endmodule

bind bulk_in_ep bulk_in_ep_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_en      (cfg_en),
    .bus_in_tok  (bus_in_tok),
    .bus_ack     (bus_ack),
    .fw_wr       (fw_wr),
    .fw_clr_rdy  (fw_clr_rdy),
    .fw_clr_cmpl (fw_clr_cmpl),
    .resp_nak    (resp_nak),
    .pkt_start   (pkt_start),
    .byte_vld    (byte_vld),
    .pkt_end     (pkt_end),
    .st_rdy      (st_rdy),
    .st_cmpl     (st_cmpl),
    .st_toggle   (st_toggle),
    .st_count    (st_count),
    .wr_err      (wr_err)
);

// File: tb/test_bulk_in_ep.sv
module test_bulk_in_ep;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_en = 1'b1;
    logic fw_wr = 1'b0, fw_set_rdy = 1'b0, fw_clr_rdy = 1'b0, fw_clr_cmpl = 1'b0;
    logic fw_ie_wr = 1'b0, fw_ie_val = 1'b0;
    logic [7:0] fw_wdata = '0;
    logic bus_in_tok = 1'b0, bus_ack = 1'b0, bus_tmo = 1'b0;
    logic resp_nak, pkt_start, tx_pid, byte_vld, pkt_end;
    logic st_rdy, st_cmpl, st_ie, st_toggle, wr_err, irq;
    logic [7:0] tx_data;
    logic [6:0] st_count;

    int checks = 0, fails = 0;
    bit done = 0;
    bit exp_tgl = 0;
    logic [7:0] got [64];
    int rkind, rlen;
    bit rpid;

    always #4 clk = ~clk;

    bulk_in_ep i_bulk_in_ep (
        .clk(clk), .rst(rst), .cfg_en(cfg_en),
        .fw_wr(fw_wr), .fw_wdata(fw_wdata), .fw_set_rdy(fw_set_rdy),
        .fw_clr_rdy(fw_clr_rdy), .fw_clr_cmpl(fw_clr_cmpl),
        .fw_ie_wr(fw_ie_wr), .fw_ie_val(fw_ie_val),
        .bus_in_tok(bus_in_tok), .bus_ack(bus_ack), .bus_tmo(bus_tmo),
        .resp_nak(resp_nak), .pkt_start(pkt_start), .tx_pid(tx_pid),
        .byte_vld(byte_vld), .tx_data(tx_data), .pkt_end(pkt_end),
        .st_rdy(st_rdy), .st_cmpl(st_cmpl), .st_ie(st_ie), .st_toggle(st_toggle),
        .st_count(st_count), .wr_err(wr_err), .irq(irq)
    );

    function automatic logic [7:0] pat(int l, int i);
        return 8'((l * 37 + i * 11 + 5) & 255);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_byte(logic [7:0] d);
        fw_wr = 1'b1; fw_wdata = d; tick(); fw_wr = 1'b0;
    endtask

    task automatic set_rdy();
        fw_set_rdy = 1'b1; tick(); fw_set_rdy = 1'b0;
    endtask

    task automatic clr_rdy();
        fw_clr_rdy = 1'b1; tick(); fw_clr_rdy = 1'b0;
    endtask

    task automatic clr_cmpl();
        fw_clr_cmpl = 1'b1; tick(); fw_clr_cmpl = 1'b0;
    endtask

    task automatic set_ie(bit v);
        fw_ie_wr = 1'b1; fw_ie_val = v; tick(); fw_ie_wr = 1'b0;
    endtask

    task automatic ack();
        bus_ack = 1'b1; tick(); bus_ack = 1'b0;
    endtask

    task automatic tmo();
        bus_tmo = 1'b1; tick(); bus_tmo = 1'b0;
    endtask

    // kind: 0 no reply, 1 NAK, 2 data packet (waits until the verdict phase)
    task automatic do_in();
        bus_in_tok = 1'b1; tick(); bus_in_tok = 1'b0;
        rkind = 0; rlen = 0; rpid = 0;
        for (int c = 0; c < 80; c++) begin
            if (resp_nak) begin rkind = 1; break; end
            if (pkt_start) begin rkind = 2; rpid = tx_pid; end
            if (byte_vld && rlen < 64) begin got[rlen] = tx_data; rlen++; end
            if (pkt_end) break;
            tick();
        end
        tick();
    endtask

    task automatic chk_pkt(int len, bit pid, string req);
        int bad;
        bad = 0;
        chk(rkind == 2, req, rkind, 2);
        chk(rpid == pid, req, rpid, pid);
        chk(rlen == len, req, rlen, len);
        for (int i = 0; i < len && i < rlen; i++)
            if (got[i] != pat(len, i)) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // reset state
        chk(!st_rdy && !st_cmpl && !irq && !st_toggle, "R7 reset", {st_rdy, st_cmpl, irq, st_toggle}, 0);
        chk(st_count == 0, "R3 reset count", st_count, 0);

        // R2: NAK while not armed
        do_in();
        chk(rkind == 1, "R2 nak", rkind, 1);

        // sweep of all packet lengths
        for (int len = 0; len <= 64; len++) begin
            set_ie(len[0]);
            for (int i = 0; i < len; i++) wr_byte(pat(len, i));
            chk(st_count == len, "R3 count", st_count, len);
            set_rdy();
            if (len % 5 == 2) begin
                do_in();
                chk_pkt(len, exp_tgl, "R3 first send");
                tmo();
                chk(st_rdy && st_count == len && !st_cmpl, "R8 still armed", st_count, len);
                do_in();
                chk_pkt(len, exp_tgl, "R8 retry");
            end else begin
                do_in();
                chk_pkt(len, exp_tgl, len == 0 ? "R4 zero length" : "R3 send");
            end
            ack();
            exp_tgl = ~exp_tgl;
            chk(st_cmpl && !st_rdy && st_count == 0, "R6 retire", {st_cmpl, st_rdy}, 2);
            chk(st_toggle == exp_tgl, "R6 toggle", st_toggle, exp_tgl);
            chk(irq == len[0], "R7 irq", irq, len[0]);
            if (len % 8 == 0) begin
                do_in();
                chk(rkind == 1, "R6 nak after ack", rkind, 1);
                wr_byte(8'h55);
                chk(wr_err && st_count == 0, "R10 write while complete", st_count, 0);
            end
            clr_cmpl();
            chk(!st_cmpl && !irq, "R7 clear", {st_cmpl, irq}, 0);
        end

        // R9: overflow
        for (int i = 0; i < 64; i++) wr_byte(8'(i));
        wr_byte(8'hAA);
        chk(wr_err == 1'b1, "R9 err", wr_err, 1);
        chk(st_count == 64, "R9 count", st_count, 64);
        clr_rdy();
        chk(st_count == 0 && !st_rdy, "R5 flush idle", st_count, 0);

        // R10: write while armed
        wr_byte(8'h11);
        set_rdy();
        wr_byte(8'h22);
        chk(wr_err && st_count == 1, "R10 write while armed", st_count, 1);

        // R12: stray verdicts while idle and armed
        ack();
        tmo();
        chk(!st_cmpl && st_rdy && st_count == 1 && st_toggle == exp_tgl, "R12 ignored", st_count, 1);

        // R5: cancel mid-stream
        clr_rdy();
        for (int i = 0; i < 10; i++) wr_byte(8'(i));
        set_rdy();
        bus_in_tok = 1'b1; tick(); bus_in_tok = 1'b0;
        repeat (4) tick();
        clr_rdy();
        chk(st_count == 0 && !st_rdy, "R5 cancel", st_count, 0);
        begin
            int ends = 0;
            for (int i = 0; i < 12; i++) begin if (pkt_end || byte_vld) ends++; tick(); end
            chk(ends == 0, "R5 stream stopped", ends, 0);
        end
        do_in();
        chk(rkind == 1, "R5 nak after cancel", rkind, 1);

        // R5: cancel after timeout, toggle kept
        for (int i = 0; i < 3; i++) wr_byte(pat(3, i));
        set_rdy();
        do_in();
        chk_pkt(3, exp_tgl, "R3 before cancel");
        tmo();
        clr_rdy();
        chk(st_toggle == exp_tgl && !st_cmpl, "R5 cancel keeps toggle", st_toggle, exp_tgl);
        do_in();
        chk(rkind == 1, "R5 nak", rkind, 1);

        // R11: ACK and cancel in the same cycle
        wr_byte(pat(1, 0));
        set_rdy();
        do_in();
        chk_pkt(1, exp_tgl, "R11 send");
        bus_ack = 1'b1; fw_clr_rdy = 1'b1; tick(); bus_ack = 1'b0; fw_clr_rdy = 1'b0;
        exp_tgl = ~exp_tgl;
        chk(st_cmpl && st_toggle == exp_tgl && st_count == 0, "R11 ack wins", {st_cmpl, st_toggle}, {1'b1, exp_tgl});
        clr_cmpl();

        // R1: disabled endpoint
        wr_byte(pat(2, 0)); wr_byte(pat(2, 1));
        set_rdy();
        cfg_en = 1'b0;
        tick();
        chk(st_toggle == 1'b0, "R1 toggle reset", st_toggle, 0);
        do_in();
        chk(rkind == 0, "R1 no reply", rkind, 0);
        cfg_en = 1'b1;
        exp_tgl = 0;
        tick();
        do_in();
        chk_pkt(2, 1'b0, "R1 re-enabled DATA0");
        ack();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule